// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page translations. Each slot holds a virtual page tag, an address-space identifier, a global flag, a physical page number and an attribute word. The attribute word carries per-privilege-mode read and write enables and two fault-on-access flags. Any number of slots can be compared against a request in parallel. A lookup presents a virtual page and the current address-space identifier. In the same cycle it returns a hit flag together with the physical page and attributes of the matching slot.

A single next-to-replace pointer chooses where new translations go. Each insert takes the slot under the pointer and moves the pointer forward one place, wrapping at the end. Three maintenance commands clear slots: clear everything, clear only the non-global slots, and clear the slots that one page/identifier pair would hit. An index port always shows the slot under the pointer, so software can walk the table. A separate advance input steps the pointer without writing.

A zero `DEPTH` selects the depth from `DATA_SIDE`: 48 slots for an instruction-side instance and 64 slots for a data-side instance.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and that is either global or stores an identifier equal to `lk_asn`. On a hit, `lk_ppn` and `lk_attr` carry that slot's fields. On a miss, `lk_hit`, `lk_ppn` and `lk_attr` are all zero.
- R2: When several slots match, the slot with the lowest index supplies the result.
- R3: An insert writes every field of the slot under the pointer and sets it valid, replacing whatever was there. The pointer then moves forward by one.
- R4: The pointer wraps from DEPTH-1 to 0.
- R5: Flush-all clears every valid bit and returns the pointer to slot 0.
- R6: Flush-local clears every slot whose global flag is 0 and keeps every global slot.
- R7: Flush-address clears every slot that a lookup of (`fl_vpn`, `fl_asn`) would match under the R1 rule. All other slots are untouched.
- R8: The `idx_*` outputs always show the slot under the pointer. `idx_adv` moves the pointer forward by one when no other operation is active. When `idx_adv` is 0 and nothing else is requested, the pointer and all slots hold.
- R9: Requests are taken in this priority order: flush-all, flush-local, flush-address, insert, advance. Only the winner acts in a cycle. An insert that arrives with `idx_adv` moves the pointer by exactly one.
- R10: After reset, no slot is valid, the pointer is 0 and every lookup misses.
- R11: The lookup path is combinational. Changes made by insert and by the flushes become visible only after the next rising clock edge.
- R12: The attribute word holds read enables for modes 0..MODES-1 in bits [MODES-1:0] and write enables in bits [2*MODES-1:MODES]. Bit 2*MODES is fault-on-read and bit 2*MODES+1 is fault-on-write. The word is stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_ppn | output | PPN_W | Physical page of the match |
| lk_attr | output | 2*MODES+2 | Attribute word of the match |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_asn | input | ASN_W | Identifier to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_attr | input | 2*MODES+2 | Attribute word to insert |
| flush_all | input | 1 | Clear all slots and reset the pointer |
| flush_local | input | 1 | Clear the non-global slots |
| flush_addr | input | 1 | Clear the slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for flush-address |
| fl_asn | input | ASN_W | Identifier for flush-address |
| idx_adv | input | 1 | Advance the pointer |
| idx_ptr | output | $clog2(depth) | Current pointer |
| idx_valid | output | 1 | Valid bit of the slot under the pointer |
| idx_vpn | output | VPN_W | Tag under the pointer |
| idx_asn | output | ASN_W | Identifier under the pointer |
| idx_global | output | 1 | Global flag under the pointer |
| idx_ppn | output | PPN_W | Physical page under the pointer |
| idx_attr | output | 2*MODES+2 | Attribute word under the pointer |

## Verification
Insert can collide with any of the three flushes, and it can also collide with the pointer advance. The bench drives flush-all together with an insert, and flush-address together with an insert. It then judges from the index port and a full lookup sweep that the insert left no trace and that the pointer went where only the winning flush sends it. It also raises insert and advance together and confirms that the pointer moved by one slot, not two, with the new translation in the slot that was under the pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_FLUSH_ALL,
      OP_FLUSH_LOCAL,
      OP_FLUSH_ADDR,
      OP_INSERT,
      OP_ADVANCE
   } tlb_op_e;

   // Resolve simultaneous requests into one winning operation.
   function automatic tlb_op_e tlb_pick_op(input logic fa, input logic fl,
                                           input logic fad, input logic ins,
                                           input logic adv);
      if (fa)       return OP_FLUSH_ALL;
      else if (fl)  return OP_FLUSH_LOCAL;
      else if (fad) return OP_FLUSH_ADDR;
      else if (ins) return OP_INSERT;
      else if (adv) return OP_ADVANCE;
      else          return OP_IDLE;
   endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int DEPTH = 48,
   parameter int VPN_W = 35,
   parameter int ASN_W = 8
) (
   input  logic [DEPTH-1:0]            vld,
   input  logic [DEPTH-1:0]            glb,
   input  logic [DEPTH-1:0][VPN_W-1:0] tags,
   input  logic [DEPTH-1:0][ASN_W-1:0] asns,
   input  logic [VPN_W-1:0]            req_vpn,
   input  logic [ASN_W-1:0]            req_asn,
   output logic [DEPTH-1:0]            hits
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign hits[e] = vld[e] && (tags[e] == req_vpn) &&
                       (glb[e] || (asns[e] == req_asn));
   end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
   parameter int DEPTH = 48,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [DEPTH-1:0] req,
   output logic             any,
   output logic [PW-1:0]    idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = PW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
   parameter int DEPTH = 48,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         ptr <= '0;
      else if (step)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
   import tlb_pkg::*;
#(
   parameter int DEPTH     = 0,
   parameter bit DATA_SIDE = 1'b0,
   parameter int VPN_W     = 35,
   parameter int ASN_W     = 8,
   parameter int PPN_W     = 28,
   parameter int MODES     = 4,
   localparam int DEP = (DEPTH != 0) ? DEPTH : (DATA_SIDE ? 64 : 48),
   localparam int PW  = (DEP > 1) ? $clog2(DEP) : 1,
   localparam int AW  = 2 * MODES + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [ASN_W-1:0] lk_asn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic [AW-1:0]    lk_attr,
   input  logic             ins_en,
   input  logic [VPN_W-1:0] ins_vpn,
   input  logic [ASN_W-1:0] ins_asn,
   input  logic             ins_global,
   input  logic [PPN_W-1:0] ins_ppn,
   input  logic [AW-1:0]    ins_attr,
   input  logic             flush_all,
   input  logic             flush_local,
   input  logic             flush_addr,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [ASN_W-1:0] fl_asn,
   input  logic             idx_adv,
   output logic [PW-1:0]    idx_ptr,
   output logic             idx_valid,
   output logic [VPN_W-1:0] idx_vpn,
   output logic [ASN_W-1:0] idx_asn,
   output logic             idx_global,
   output logic [PPN_W-1:0] idx_ppn,
   output logic [AW-1:0]    idx_attr
);

   // Elaboration-time parameter checks
   if (DEP < 2) begin : g_bad_depth
      $error("asn_tlb: depth must be at least 2");
   end
   if (VPN_W < 1 || ASN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("asn_tlb: field widths must be positive");
   end
   if (MODES < 1) begin : g_bad_modes
      $error("asn_tlb: at least one privilege mode is required");
   end

   logic [DEP-1:0]            vld_q;
   logic [DEP-1:0]            glb_q;
   logic [DEP-1:0][VPN_W-1:0] tag_q;
   logic [DEP-1:0][ASN_W-1:0] asn_q;
   logic [DEP-1:0][PPN_W-1:0] ppn_q;
   logic [DEP-1:0][AW-1:0]    attr_q;

   logic [DEP-1:0] lk_match;
   logic [DEP-1:0] fl_match;
   logic [PW-1:0]  lk_idx;
   logic           lk_any;
   logic [PW-1:0]  ptr;
   tlb_op_e        op;

   assign op = tlb_pick_op(flush_all, flush_local, flush_addr, ins_en, idx_adv);

   tlb_match #(.DEPTH(DEP), .VPN_W(VPN_W), .ASN_W(ASN_W)) lk_cmp_i (
      .vld(vld_q), .glb(glb_q), .tags(tag_q), .asns(asn_q),
      .req_vpn(lk_vpn), .req_asn(lk_asn), .hits(lk_match)
   );

   tlb_match #(.DEPTH(DEP), .VPN_W(VPN_W), .ASN_W(ASN_W)) fl_cmp_i (
      .vld(vld_q), .glb(glb_q), .tags(tag_q), .asns(asn_q),
      .req_vpn(fl_vpn), .req_asn(fl_asn), .hits(fl_match)
   );

   tlb_prio_enc #(.DEPTH(DEP)) lk_enc_i (
      .req(lk_match), .any(lk_any), .idx(lk_idx)
   );

   tlb_victim_ptr #(.DEPTH(DEP)) vptr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(op == OP_FLUSH_ALL),
      .step (op == OP_INSERT || op == OP_ADVANCE),
      .ptr  (ptr)
   );

   // Per-slot storage and update
   for (genvar e = 0; e < DEP; e++) begin : g_slot
      logic             v_r;
      logic             g_r;
      logic [VPN_W-1:0] t_r;
      logic [ASN_W-1:0] a_r;
      logic [PPN_W-1:0] p_r;
      logic [AW-1:0]    x_r;
      logic             sel;

      assign sel = (ptr == PW'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            g_r <= 1'b0;
            t_r <= '0;
            a_r <= '0;
            p_r <= '0;
            x_r <= '0;
         end else begin
            unique case (op)
               OP_FLUSH_ALL:   v_r <= 1'b0;
               OP_FLUSH_LOCAL: if (!g_r) v_r <= 1'b0;
               OP_FLUSH_ADDR:  if (fl_match[e]) v_r <= 1'b0;
               OP_INSERT: begin
                  if (sel) begin
                     v_r <= 1'b1;
                     g_r <= ins_global;
                     t_r <= ins_vpn;
                     a_r <= ins_asn;
                     p_r <= ins_ppn;
                     x_r <= ins_attr;
                  end
               end
               default: ;
            endcase
         end
      end

      assign vld_q[e]  = v_r;
      assign glb_q[e]  = g_r;
      assign tag_q[e]  = t_r;
      assign asn_q[e]  = a_r;
      assign ppn_q[e]  = p_r;
      assign attr_q[e] = x_r;
   end

   // Lookup result
   assign lk_hit  = lk_any;
   assign lk_ppn  = lk_any ? ppn_q[lk_idx]  : '0;
   assign lk_attr = lk_any ? attr_q[lk_idx] : '0;

   // Index read port
   assign idx_ptr    = ptr;
   assign idx_valid  = vld_q[ptr];
   assign idx_vpn    = tag_q[ptr];
   assign idx_asn    = asn_q[ptr];
   assign idx_global = glb_q[ptr];
   assign idx_ppn    = ppn_q[ptr];
   assign idx_attr   = attr_q[ptr];

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
   parameter int DEPTH = 4,
   parameter int PW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_all,
   input logic             flush_local,
   input logic             flush_addr,
   input logic             ins_en,
   input logic             idx_adv,
   input logic [PW-1:0]    ptr,
   input logic [DEPTH-1:0] vld_q,
   input logic [DEPTH-1:0] glb_q
);
   logic [PW-1:0] ptr_nxt;
   logic          any_flush;

   assign ptr_nxt   = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   assign any_flush = flush_all || flush_local || flush_addr;

   // R5
   flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (vld_q == '0) && (ptr == '0));

   // R6
   flush_local_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_local && !flush_all) |=> ((vld_q & ~glb_q) == '0));

   // R3
   insert_fills_and_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !any_flush) |=> vld_q[$past(ptr)] && (ptr == $past(ptr_nxt)));

   // R8
   advance_steps_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_adv && !ins_en && !any_flush) |=> (ptr == $past(ptr_nxt)));

   // R8
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_en && !any_flush) |=> $stable(vld_q));

   // R4
   always_comb begin
      if (rst_n) begin
         ptr_in_range_chk: assert (ptr <= PW'(DEPTH - 1));
      end
   end
endmodule

bind asn_tlb tlb_chk #(.DEPTH(DEP), .PW(PW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_all  (flush_all),
   .flush_local(flush_local),
   .flush_addr (flush_addr),
   .ins_en     (ins_en),
   .idx_adv    (idx_adv),
   .ptr        (ptr),
   .vld_q      (vld_q),
   .glb_q      (glb_q)
);

// File: tb/asn_tlb_tb_top.sv
module asn_tlb_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int D   = 4;
   localparam int VW  = 3;
   localparam int AW_ = 2;
   localparam int PWD = 5;
   localparam int MD  = 2;
   localparam int XW  = 2 * MD + 2;
   localparam int PW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW_-1:0] lk_asn = '0;
   logic lk_hit;
   logic [PWD-1:0] lk_ppn;
   logic [XW-1:0] lk_attr;
   logic ins_en = 0, ins_global = 0;
   logic [VW-1:0] ins_vpn = '0;
   logic [AW_-1:0] ins_asn = '0;
   logic [PWD-1:0] ins_ppn = '0;
   logic [XW-1:0] ins_attr = '0;
   logic flush_all = 0, flush_local = 0, flush_addr = 0, idx_adv = 0;
   logic [VW-1:0] fl_vpn = '0;
   logic [AW_-1:0] fl_asn = '0;
   logic [PW-1:0] idx_ptr;
   logic idx_valid, idx_global;
   logic [VW-1:0] idx_vpn;
   logic [AW_-1:0] idx_asn;
   logic [PWD-1:0] idx_ppn;
   logic [XW-1:0] idx_attr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   asn_tlb #(.DEPTH(D), .VPN_W(VW), .ASN_W(AW_), .PPN_W(PWD), .MODES(MD)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
      .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_global(ins_global),
      .ins_ppn(ins_ppn), .ins_attr(ins_attr),
      .flush_all(flush_all), .flush_local(flush_local), .flush_addr(flush_addr),
      .fl_vpn(fl_vpn), .fl_asn(fl_asn),
      .idx_adv(idx_adv), .idx_ptr(idx_ptr), .idx_valid(idx_valid), .idx_vpn(idx_vpn),
      .idx_asn(idx_asn), .idx_global(idx_global), .idx_ppn(idx_ppn), .idx_attr(idx_attr)
   );

   // Requirement model
   logic           m_vld [D];
   logic           m_glb [D];
   logic [VW-1:0]  m_vpn [D];
   logic [AW_-1:0] m_asn [D];
   logic [PWD-1:0] m_ppn [D];
   logic [XW-1:0]  m_attr[D];
   int             m_ptr;

   int n_chk = 0;
   int n_bad = 0;
   bit timed_out = 0;

   function automatic bit m_hit(int i, logic [VW-1:0] v, logic [AW_-1:0] a);
      return m_vld[i] && m_vpn[i] == v && (m_glb[i] || m_asn[i] == a);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic m_reset();
      for (int i = 0; i < D; i++) begin
         m_vld[i] = 0; m_glb[i] = 0; m_vpn[i] = '0;
         m_asn[i] = '0; m_ppn[i] = '0; m_attr[i] = '0;
      end
      m_ptr = 0;
   endtask

   // One clock: update model at the edge with the driven requests (R9 order)
   task automatic tick();
      @(posedge clk);
      if (flush_all) begin
         for (int i = 0; i < D; i++) m_vld[i] = 0;
         m_ptr = 0;
      end else if (flush_local) begin
         for (int i = 0; i < D; i++) if (!m_glb[i]) m_vld[i] = 0;
      end else if (flush_addr) begin
         bit kill [D];
         for (int i = 0; i < D; i++) kill[i] = m_hit(i, fl_vpn, fl_asn);
         for (int i = 0; i < D; i++) if (kill[i]) m_vld[i] = 0;
      end else if (ins_en) begin
         m_vld[m_ptr] = 1; m_glb[m_ptr] = ins_global; m_vpn[m_ptr] = ins_vpn;
         m_asn[m_ptr] = ins_asn; m_ppn[m_ptr] = ins_ppn; m_attr[m_ptr] = ins_attr;
         m_ptr = (m_ptr + 1) % D;
      end else if (idx_adv) begin
         m_ptr = (m_ptr + 1) % D;
      end
      @(negedge clk);
      ins_en = 0; flush_all = 0; flush_local = 0; flush_addr = 0; idx_adv = 0;
   endtask

   task automatic drive_ins(logic [VW-1:0] v, logic [AW_-1:0] a, logic g,
                            logic [PWD-1:0] p, logic [XW-1:0] x);
      ins_en = 1; ins_vpn = v; ins_asn = a; ins_global = g; ins_ppn = p; ins_attr = x;
   endtask

   // Full lookup sweep against the model (R1, R2, R12)
   task automatic sweep(string req);
      for (int v = 0; v < (1 << VW); v++) begin
         for (int a = 0; a < (1 << AW_); a++) begin
            logic [31:0] exp;
            exp = '0;
            lk_vpn = VW'(v); lk_asn = AW_'(a);
            #1;
            for (int i = D - 1; i >= 0; i--)
               if (m_hit(i, VW'(v), AW_'(a)))
                  exp = {19'd0, 1'b1, m_ppn[i], m_attr[i]};
            chk(req, {19'd0, lk_hit, lk_ppn, lk_attr}, exp);
         end
      end
      @(negedge clk);
   endtask

   task automatic chk_idx(string req);
      chk(req, 32'(idx_ptr), 32'(m_ptr));
      chk(req, 32'(idx_valid), 32'(m_vld[m_ptr]));
      if (m_vld[m_ptr])
         chk(req, {14'd0, idx_global, idx_vpn, idx_asn, idx_ppn, idx_attr},
             {14'd0, m_glb[m_ptr], m_vpn[m_ptr], m_asn[m_ptr], m_ppn[m_ptr], m_attr[m_ptr]});
   endtask

   task automatic run_all();
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk("R10", 32'(idx_ptr), 0);
      chk("R10", 32'(idx_valid), 0);
      sweep("R10");

      // Fill: slots 0 and 1 share a tag for R2
      drive_ins(3, 1, 0, 5'h11, 6'h05); tick();
      drive_ins(3, 0, 1, 5'h12, 6'h2A); tick();
      drive_ins(5, 2, 0, 5'h13, 6'h3F); tick();
      drive_ins(1, 3, 1, 5'h14, 6'h10); tick();
      lk_vpn = 3; lk_asn = 1; #1;
      chk("R2", {lk_hit, lk_ppn}, {1'b1, 5'h11});
      lk_asn = 2; #1;
      chk("R2", {lk_hit, lk_ppn}, {1'b1, 5'h12});
      @(negedge clk);
      sweep("R1 R12");
      chk("R4", 32'(idx_ptr), 0);

      // Index walk (R8)
      for (int k = 0; k < D; k++) begin
         chk_idx("R8");
         idx_adv = 1; tick();
      end
      tick();
      chk_idx("R8");

      // R11: insert not visible before the edge
      drive_ins(6, 0, 0, 5'h1C, 6'h21);
      lk_vpn = 6; lk_asn = 0; #1;
      chk("R11", 32'(lk_hit), 0);
      tick();
      lk_vpn = 6; lk_asn = 0; #1;
      chk("R11", {lk_hit, lk_ppn, lk_attr}, {1'b1, 5'h1C, 6'h21});
      @(negedge clk);
      sweep("R3");
      chk_idx("R3");

      // R7 flush by address: global slot hit via any identifier, then a non-match
      flush_addr = 1; fl_vpn = 3; fl_asn = 2; tick();
      sweep("R7");
      flush_addr = 1; fl_vpn = 5; fl_asn = 1; tick();
      sweep("R7");

      // R9 flush-address beats insert
      flush_addr = 1; fl_vpn = 7; fl_asn = 0;
      drive_ins(7, 0, 1, 5'h0F, 6'h3C); tick();
      sweep("R9");
      chk_idx("R9");

      // R9 insert with advance moves pointer once
      drive_ins(2, 1, 1, 5'h07, 6'h0A); idx_adv = 1; tick();
      chk_idx("R9");
      sweep("R9");

      // R6 flush non-global
      flush_local = 1; tick();
      sweep("R6");
      chk_idx("R6");

      // R5 with R9: flush-all beats insert
      flush_all = 1; drive_ins(4, 2, 1, 5'h19, 6'h11); tick();
      chk("R5", 32'(idx_ptr), 0);
      sweep("R5");
      chk_idx("R5");

      // Refill past wrap (R4, R3)
      for (int k = 0; k < D + 2; k++) begin
         drive_ins(VW'(k * 3 + 1), AW_'(k), k[0], PWD'(k * 7 + 3), XW'(k * 11 + 5));
         tick();
         chk_idx("R4");
      end
      sweep("R3 R4");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule